// File: doc/BRIEF.md
# Pipelined Byte-Lane SRAM

A synchronous single-port memory whose word is split into byte lanes of nine bits each (eight data bits and one parity bit). The default is four lanes, so the word is 36 bits. Every input is captured on the rising clock edge: address, write data, the three chip enables and the write controls. A captured write is committed at the next edge with no further handshake. A captured read presents its word through an output register one clock later.

The shared bidirectional data bus is modelled as a separate input bus and output bus. An enable flag marks the cycles in which the three-state driver would be on. While the flag is low the output bus is held at zero.

Writes can touch any subset of lanes. A lane is written when the lane-write enable and that lane's pick bit are both high. The all-lanes write input overrides both and writes the full word. If a selected cycle ends up with no lane to write, it is a read. Depth expansion uses the three chip enables. A deselect turns the output enable off after a single cycle and blocks any write.

Top module: `sram_pipe_bw`

## Requirements
- R1: The block is selected only when `en_a_n`=0, `en_b`=1 and `en_c_n`=0, all three sampled at the same rising edge as `addr`.
- R2: A selected read captured at edge k drives the stored word on `dout` with `dout_en`=1 after edge k+1.
- R3: Lane n covers `din`/`dout` bits 9n+8 down to 9n. With `all_lanes_wr`=0, lane n is written only when both `lane_wr_en`=1 and `lane_pick[n]`=1. All other lanes keep their contents.
- R4: When `all_lanes_wr`=1 in a selected cycle, every lane is written from `din`, whatever `lane_wr_en` and `lane_pick` hold.
- R5: A selected cycle that writes at least one lane gives `dout_en`=0 after the next edge.
- R6: A deselected cycle gives `dout_en`=0 after the next edge and leaves the memory contents unchanged.
- R7: A selected cycle with `all_lanes_wr`=0 and either `lane_wr_en`=0 or `lane_pick`=0 is a read and leaves the memory unchanged.
- R8: A read captured one edge after a write to the same address returns the newly written data.
- R9: While `rst_n` is low, and after its release until the first captured read completes, `dout_en`=0 and `dout`=0.
- R10: Whenever `dout_en`=0, `dout` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of control and output registers |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| all_lanes_wr | input | 1 | Writes the full word when high |
| lane_wr_en | input | 1 | Enables per-lane writes |
| lane_pick | input | LANES (4) | Per-lane write selects |
| addr | input | ADDR_W (6) | Word address |
| din | input | LANES*LANE_W (36) | Write data |
| dout | output | LANES*LANE_W (36) | Registered read data, zero when not enabled |
| dout_en | output | 1 | Output-drive flag, high for one cycle per completed read |

## Verification
The embedded assertions check, on every cycle, that the chip-enable decode reaches the select register one edge later. They also check that the all-lanes override produces a full mask and that no unpicked lane is masked in without the override. Further per-cycle checks: a cycle with no lanes to write is classed as a read, each captured read or write sets or clears the output flag one edge later, and the output is zero while the flag is low. Only the bench scenarios can show that stored contents are right: that partial writes leave the other lanes intact, that deselected or lane-less cycles do not disturb the memory, and that a read immediately after a write returns the merged word.

// File: rtl/sram_pipe_pkg.sv
package sram_pipe_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } sram_op_e;
endpackage

// File: rtl/sram_in_stage.sv
module sram_in_stage #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 36,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_a_n,
   input  logic              en_b,
   input  logic              en_c_n,
   input  logic              all_lanes_wr,
   input  logic              lane_wr_en,
   input  logic [LANES-1:0]  lane_pick,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic              sel_q,
   output logic              all_q,
   output logic              wen_q,
   output logic [LANES-1:0]  pick_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] din_q
);
   logic sel_d;
   assign sel_d = !en_a_n && en_b && !en_c_n;

   // control registers carry a reset, the datapath does not
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q  <= 1'b0;
         all_q  <= 1'b0;
         wen_q  <= 1'b0;
         pick_q <= '0;
      end else begin
         sel_q  <= sel_d;
         all_q  <= all_lanes_wr;
         wen_q  <= lane_wr_en;
         pick_q <= lane_pick;
      end
   end

   always_ff @(posedge clk) begin
      addr_q <= addr;
      din_q  <= din;
   end

   a_r1_select_decode: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_a_n && en_b && !en_c_n) |=> sel_q);

   a_r6_single_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      (en_a_n || !en_b || en_c_n) |=> !sel_q);
endmodule

// File: rtl/sram_wmask.sv
module sram_wmask
   import sram_pipe_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             all_wr,
   input  logic             wen,
   input  logic [LANES-1:0] pick,
   output logic [LANES-1:0] mask,
   output sram_op_e         op
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign mask[i] = sel && (all_wr || (wen && pick[i]));
   end

   always_comb begin
      if (!sel)       op = OP_IDLE;
      else if (|mask) op = OP_WRITE;
      else            op = OP_READ;
   end

   a_r4_override_full: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && all_wr) |-> (&mask));

   a_r3_lane_needs_pick: assert property (@(posedge clk) disable iff (!rst_n)
      !all_wr |-> ((mask & ~pick) == '0));

   a_r7_empty_is_read: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !all_wr && (!wen || pick == '0)) |-> (op == OP_READ));

   a_r6_no_mask_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |-> (mask == '0));
endmodule

// File: rtl/sram_array.sv
module sram_array #(
   parameter int ADDR_W = 6,
   parameter int LANE_W = 9,
   parameter int LANES  = 4
) (
   input  logic                      clk,
   input  logic [LANES-1:0]          we_mask,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [LANES*LANE_W-1:0]   wdata,
   output logic [LANES*LANE_W-1:0]   rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar i = 0; i < LANES; i++) begin : g_bank
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (we_mask[i]) mem[addr] <= wdata[i*LANE_W +: LANE_W];
      end

      assign rdata[i*LANE_W +: LANE_W] = mem[addr];
   end
endmodule

// File: rtl/sram_pipe_bw.sv
module sram_pipe_bw
   import sram_pipe_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANE_W = 9,
   parameter int LANES  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en_a_n,
   input  logic                    en_b,
   input  logic                    en_c_n,
   input  logic                    all_lanes_wr,
   input  logic                    lane_wr_en,
   input  logic [LANES-1:0]        lane_pick,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] din,
   output logic [LANES*LANE_W-1:0] dout,
   output logic                    dout_en
);
   localparam int DATA_W = LANES * LANE_W;

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("sram_pipe_bw: ADDR_W out of range");
   end
   if (LANE_W < 1 || LANES < 1) begin : g_bad_lane
      $error("sram_pipe_bw: lane geometry must be non-empty");
   end

   logic              sel_q, all_q, wen_q;
   logic [LANES-1:0]  pick_q, mask;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] din_q, arr_rd;
   sram_op_e          op;

   sram_in_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_in (
      .clk(clk), .rst_n(rst_n),
      .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
      .all_lanes_wr(all_lanes_wr), .lane_wr_en(lane_wr_en),
      .lane_pick(lane_pick), .addr(addr), .din(din),
      .sel_q(sel_q), .all_q(all_q), .wen_q(wen_q),
      .pick_q(pick_q), .addr_q(addr_q), .din_q(din_q)
   );

   sram_wmask #(.LANES(LANES)) u_mask (
      .clk(clk), .rst_n(rst_n),
      .sel(sel_q), .all_wr(all_q), .wen(wen_q), .pick(pick_q),
      .mask(mask), .op(op)
   );

   sram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_arr (
      .clk(clk), .we_mask(mask), .addr(addr_q),
      .wdata(din_q), .rdata(arr_rd)
   );

   // output register: one stage after capture
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout_en <= 1'b0;
         dout    <= '0;
      end else begin
         dout_en <= (op == OP_READ);
         dout    <= (op == OP_READ) ? arr_rd : '0;
      end
   end

   a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_READ) |=> dout_en);

   a_r5_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_WRITE) |=> !dout_en);

   a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_IDLE) |=> !dout_en);

   a_r10_zero_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_en |-> (dout == '0));
endmodule

// File: tb/sim_sram_pipe_bw.sv
module sim_sram_pipe_bw;
   localparam int AW = 6;
   localparam int LW = 9;
   localparam int NL = 4;
   localparam int DW = NL * LW;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n;
   logic          en_a_n, en_b, en_c_n, all_lanes_wr, lane_wr_en;
   logic [NL-1:0] lane_pick;
   logic [AW-1:0] addr;
   logic [DW-1:0] din, dout;
   logic          dout_en;

   sram_pipe_bw #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) u0 (
      .clk(clk), .rst_n(rst_n), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
      .all_lanes_wr(all_lanes_wr), .lane_wr_en(lane_wr_en), .lane_pick(lane_pick),
      .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
   );

   logic [DW-1:0] ref_mem [DEPTH];
   int n_run = 0;
   int n_fail = 0;

   bit            pl_live [2];
   bit            pl_v    [2];
   logic [DW-1:0] pl_d    [2];
   string         pl_tag  [2];

   function automatic logic [NL-1:0] exp_mask(bit sel, bit g, bit b, logic [NL-1:0] ls);
      if (!sel) return '0;
      if (g) return '1;
      return b ? ls : '0;
   endfunction

   function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw,
                                           logic [NL-1:0] m);
      logic [DW-1:0] r = old;
      for (int i = 0; i < NL; i++)
         if (m[i]) r[i*LW +: LW] = nw[i*LW +: LW];
      return r;
   endfunction

   // expected data is zero when the flag is low (R10)
   task automatic check(string tag, bit ev, logic [DW-1:0] ed);
      n_run++;
      if (dout_en !== ev || dout !== ed) begin
         n_fail++;
         $display("FAIL %s: got en=%0b dout=%h, expected en=%0b dout=%h",
                  tag, dout_en, dout, ev, ed);
      end
   endtask

   // called at a negedge: checks the op issued two negedges ago, drives a new one
   task automatic step(bit c1, bit c2, bit c3, bit g, bit b, logic [NL-1:0] ls,
                       logic [AW-1:0] a, logic [DW-1:0] d, string tag);
      bit sel;
      logic [NL-1:0] m;
      if (pl_live[1]) check(pl_tag[1], pl_v[1], pl_d[1]);
      pl_live[1] = pl_live[0]; pl_v[1] = pl_v[0]; pl_d[1] = pl_d[0]; pl_tag[1] = pl_tag[0];
      sel = !c1 && c2 && !c3;
      m   = exp_mask(sel, g, b, ls);
      pl_live[0] = 1'b1;
      pl_v[0]    = sel && (m == '0);
      pl_d[0]    = pl_v[0] ? ref_mem[a] : '0;
      pl_tag[0]  = tag;
      if (m != '0) ref_mem[a] = merge(ref_mem[a], d, m);
      en_a_n = c1; en_b = c2; en_c_n = c3;
      all_lanes_wr = g; lane_wr_en = b; lane_pick = ls; addr = a; din = d;
      @(negedge clk);
   endtask

   task automatic rd(logic [AW-1:0] a, string tag);
      step(0, 1, 0, 0, 0, '0, a, {$urandom, $urandom}, tag);
   endtask

   task automatic idle(string tag);
      step(1, 1, 0, 1, 1, '1, AW'($urandom), {$urandom, $urandom}, tag);
   endtask

   function automatic logic [DW-1:0] rnd_word();
      return {$urandom, $urandom};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      pl_live[0] = 0; pl_live[1] = 0;
      rst_n = 0; en_a_n = 1; en_b = 0; en_c_n = 1;
      all_lanes_wr = 0; lane_wr_en = 0; lane_pick = '0; addr = '0; din = '0;
      repeat (4) @(negedge clk);
      check("R9 in reset", 0, '0);
      rst_n = 1;
      @(negedge clk);
      check("R9 after release", 0, '0);

      // fill every word through the all-lanes override (R4, R5)
      for (int a = 0; a < DEPTH; a++)
         step(0, 1, 0, 1, 0, '0, AW'(a), rnd_word(), "R5 fill write");
      for (int a = 0; a < 8; a++) rd(AW'(a * 7), "R2 read");

      // partial lane write, then read right after (R3, R8)
      step(0, 1, 0, 0, 1, 4'b0101, 6'd5, rnd_word(), "R3 lanes 0,2");
      rd(6'd5, "R8 read after partial write");
      step(0, 1, 0, 0, 1, 4'b1000, 6'd5, rnd_word(), "R3 lane 3");
      rd(6'd5, "R3 lane 3 merge");

      // override ignores lane controls (R4)
      step(0, 1, 0, 1, 0, 4'b0000, 6'd9, rnd_word(), "R4 override");
      rd(6'd9, "R4 override read");

      // lane-less cycles are reads (R7)
      step(0, 1, 0, 0, 1, 4'b0000, 6'd12, rnd_word(), "R7 no lanes picked");
      step(0, 1, 0, 0, 0, 4'b1111, 6'd12, rnd_word(), "R7 lane enable off");
      rd(6'd12, "R7 contents kept");

      // each chip enable alone deselects and blocks writes (R1, R6)
      step(1, 1, 0, 1, 1, '1, 6'd20, rnd_word(), "R1 en_a_n high");
      step(0, 0, 0, 1, 1, '1, 6'd20, rnd_word(), "R1 en_b low");
      step(0, 1, 1, 1, 1, '1, 6'd20, rnd_word(), "R1 en_c_n high");
      rd(6'd20, "R6 deselected write blocked");
      rd(6'd21, "R2 back to back read");
      idle("R6 single cycle deselect");
      rd(6'd21, "R2 read after idle");

      // random mix
      for (int n = 0; n < 4000; n++) begin
         bit c1 = ($urandom % 8) == 0;
         bit c2 = ($urandom % 8) != 0;
         bit c3 = ($urandom % 8) == 0;
         bit g  = ($urandom % 4) == 0;
         bit b  = ($urandom % 2) == 0;
         logic [NL-1:0] ls = NL'($urandom);
         bit sel = !c1 && c2 && !c3;
         logic [NL-1:0] m = exp_mask(sel, g, b, ls);
         string tg = !sel ? "R6 random deselect" :
                     (m != '0) ? "R3 random write" : "R2 random read";
         step(c1, c2, c3, g, b, ls, AW'($urandom), rnd_word(), tg);
      end
      idle("R10 flush"); idle("R10 flush"); idle("R10 flush");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule